// File: doc/BRIEF.md
# Automatic Chip Erase Sequencer

This block erases an entire memory array on its own once the host has issued a two-step start: an erase set-up command, then an erase confirm command. The host does not need to program the array beforehand. The sequencer first writes zero to every word and reads each one back. Only when the whole array reads zero does it apply a timed erase strobe. It then checks every word for all ones.

Both the program phase and the erase phase retry a failing word a limited number of times. In the program phase, a word that does not read zero is written again. In the erase phase, a word that does not read all ones causes another full erase pulse, after which checking resumes at that same word. If a word still fails after the allowed retries, the matching fail bit is set and the sequence stops. The host only needs to watch a status port. While a sequence runs, every command is ignored.

The memory port connects to a behavioural array. Reads are combinational on the address. A write stores the write data, which is always zero. The erase strobe sets every word to all ones.

Top module: `chip_erase_seq`

## Requirements
- R1: A sequence starts only when an erase confirm code (0xD0) arrives as the very next command after a set-up code (0x20) while idle. A confirm with no set-up before it, or with any other command in between, leaves the block idle.
- R2: The status port reads as follows: bit 0 busy, bit 1 done, bit 2 program fail, bit 3 erase fail. Busy reads 1 in the cycle after the confirm is accepted. In that same cycle, done and both fail bits read 0.
- R3: The program phase handles addresses 0 upward, one after another. Each address gets a one-cycle write of zero, followed by a one-cycle read-back. The address advances when the read-back is zero. This works from any starting array content.
- R4: If a program read-back is not zero, the word is written again, up to MAX_RETRY retries. If it fails after the last retry, program fail is set, busy clears, and no erase strobe is ever issued.
- R5: The erase strobe starts only after the last address has read back zero in the program phase. Each erase pulse holds the strobe for exactly ERASE_CYC consecutive cycles.
- R6: The erase check starts at address 0 and moves upward. It spends one cycle per address and advances when the word reads all ones.
- R7: If an erase check reads a value that is not all ones, another erase pulse follows. Checking then resumes at the same address. Each address allows up to MAX_RETRY extra pulses. If the word still fails after that, erase fail is set and busy clears.
- R8: When the last address reads all ones, done is set and busy clears in the same cycle. The array then holds all ones.
- R9: Commands that arrive while busy have no effect. This includes set-up/confirm pairs. A set-up sent while busy does not arm a start for a confirm that arrives after the sequence ends.
- R10: While busy is 0, the memory write and erase strobes stay low. This includes the state right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe from the command decoder |
| cmd_code | input | CMD_W | Command code |
| mem_addr | output | AW | Array word address |
| mem_we | output | 1 | Write strobe for the addressed word |
| mem_wdata | output | DW | Write data, always zero |
| mem_erase | output | 1 | Whole-array erase strobe |
| mem_rdata | input | DW | Combinational read data of the addressed word |
| status | output | 4 | {erase fail, program fail, done, busy} |

## Verification
The in-RTL properties are checked on every cycle. They cover the following: busy follows an accepted start, each erase pulse ends only when the timer has expired, the erase strobe begins only from a check state, checking resumes at the same address after a re-erase, the retry count stays within its limit, the two fail bits never appear together, and done rises with busy low. The bench scenarios cover what depends on the contents of the array. These are the addresses walked in order, the number of writes and pulses spent on weak words, stopping without an erase after a program failure, and the array ending at all ones. The bench scenarios also check command gating: commands are rejected while idle-but-unarmed and while busy.

// File: rtl/chip_erase_pkg.sv
package chip_erase_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PROG,
    PH_PVFY,
    PH_ERASE,
    PH_EVFY
  } phase_e;

  typedef struct packed {
    logic erase_fail;
    logic prog_fail;
    logic done;
    logic busy;
  } stat_t;
endpackage

// File: rtl/ces_cmd.sv
module ces_cmd #(
  parameter int              CMD_W       = 8,
  parameter logic [CMD_W-1:0] CMD_SETUP   = 8'h20,
  parameter logic [CMD_W-1:0] CMD_CONFIRM = 8'hD0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             busy_i,
  output logic             start_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (busy_i)           armed_d = 1'b0;
    else if (cmd_valid_i) armed_d = (cmd_code_i == CMD_SETUP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign start_o = cmd_valid_i && !busy_i && armed_q && (cmd_code_i == CMD_CONFIRM);
endmodule

// File: rtl/ces_ctr.sv
module ces_ctr #(
  parameter int AW        = 4,
  parameter int MAX_RETRY = 3,
  parameter int ERASE_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_clr_i,
  input  logic          addr_inc_i,
  input  logic          try_clr_i,
  input  logic          try_inc_i,
  input  logic          tmr_run_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_last_o,
  output logic          try_max_o,
  output logic          tmr_done_o
);
  localparam int TRW = $clog2(MAX_RETRY + 2);
  localparam int TMW = $clog2(ERASE_CYC + 1);

  logic [AW-1:0]  addr_q, addr_d;
  logic [TRW-1:0] try_q, try_d;
  logic [TMW-1:0] tmr_q, tmr_d;
  logic           addr_en, try_en;

  assign addr_en = addr_clr_i | addr_inc_i;
  assign try_en  = try_clr_i | try_inc_i;

  always_comb begin
    addr_d = addr_clr_i ? '0 : addr_q + 1'b1;
    try_d  = try_clr_i  ? '0 : try_q + 1'b1;
    tmr_d  = tmr_run_i  ? tmr_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      try_q  <= '0;
      tmr_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (try_en)  try_q  <= try_d;
      tmr_q <= tmr_d;
    end
  end

  assign addr_o      = addr_q;
  assign addr_last_o = &addr_q;
  assign try_max_o   = (try_q == TRW'(MAX_RETRY));
  assign tmr_done_o  = (tmr_q == TMW'(ERASE_CYC - 1));

  assert_try_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    try_q <= TRW'(MAX_RETRY));
endmodule

// File: rtl/ces_fsm.sv
module ces_fsm
  import chip_erase_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_last_i,
  input  logic          try_max_i,
  input  logic          tmr_done_i,
  output logic          mem_we_o,
  output logic          mem_erase_o,
  output logic          addr_clr_o,
  output logic          addr_inc_o,
  output logic          try_clr_o,
  output logic          try_inc_o,
  output logic          tmr_run_o,
  output stat_t         stat_o
);
  phase_e state_q, state_d;
  logic   done_q, done_d, pf_q, pf_d, ef_q, ef_d, flag_en;
  logic   rd_zero, rd_ones;

  assign rd_zero = (mem_rdata_i == '0);
  assign rd_ones = &mem_rdata_i;

  always_comb begin
    state_d    = state_q;
    done_d     = done_q;
    pf_d       = pf_q;
    ef_d       = ef_q;
    addr_clr_o = 1'b0;
    addr_inc_o = 1'b0;
    try_clr_o  = 1'b0;
    try_inc_o  = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start_i) begin
        state_d    = PH_PROG;
        addr_clr_o = 1'b1;
        try_clr_o  = 1'b1;
        done_d     = 1'b0;
        pf_d       = 1'b0;
        ef_d       = 1'b0;
      end
      PH_PROG: state_d = PH_PVFY;
      PH_PVFY: begin
        if (rd_zero) begin
          try_clr_o = 1'b1;
          if (addr_last_i) begin
            state_d    = PH_ERASE;
            addr_clr_o = 1'b1;
          end else begin
            state_d    = PH_PROG;
            addr_inc_o = 1'b1;
          end
        end else if (try_max_i) begin
          state_d = PH_IDLE;
          pf_d    = 1'b1;
        end else begin
          state_d   = PH_PROG;
          try_inc_o = 1'b1;
        end
      end
      PH_ERASE: if (tmr_done_i) state_d = PH_EVFY;
      PH_EVFY: begin
        if (rd_ones) begin
          if (addr_last_i) begin
            state_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            addr_inc_o = 1'b1;
            try_clr_o  = 1'b1;
          end
        end else if (try_max_i) begin
          state_d = PH_IDLE;
          ef_d    = 1'b1;
        end else begin
          state_d   = PH_ERASE;
          try_inc_o = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign flag_en = (state_q == PH_IDLE) ? start_i : (state_d == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
      pf_q    <= 1'b0;
      ef_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flag_en) begin
        done_q <= done_d;
        pf_q   <= pf_d;
        ef_q   <= ef_d;
      end
    end
  end

  assign mem_we_o    = (state_q == PH_PROG);
  assign mem_erase_o = (state_q == PH_ERASE);
  assign tmr_run_o   = (state_q == PH_ERASE);
  assign stat_o      = '{erase_fail: ef_q, prog_fail: pf_q, done: done_q,
                         busy: (state_q != PH_IDLE)};

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> stat_o.busy);
  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_erase_o) |-> $past(tmr_done_i));
  assert_pulse_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_erase_o) |-> ($past(state_q) == PH_PVFY || $past(state_q) == PH_EVFY));
  assert_resume_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_EVFY && $past(state_q) == PH_ERASE) |-> addr_i == $past(addr_i));
  assert_fail_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_o.prog_fail && stat_o.erase_fail));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o.done) |-> !stat_o.busy);
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import chip_erase_pkg::*;
#(
  parameter int              AW          = 4,
  parameter int              DW          = 8,
  parameter int              MAX_RETRY   = 3,
  parameter int              ERASE_CYC   = 5,
  parameter int              CMD_W       = 8,
  parameter logic [CMD_W-1:0] CMD_SETUP   = 8'h20,
  parameter logic [CMD_W-1:0] CMD_CONFIRM = 8'hD0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_erase,
  input  logic [DW-1:0]    mem_rdata,
  output logic [3:0]       status
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       start, addr_clr, addr_inc, try_clr, try_inc, tmr_run;
  logic       addr_last, try_max, tmr_done;
  stat_t      stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ces_cmd #(.CMD_W(CMD_W), .CMD_SETUP(CMD_SETUP), .CMD_CONFIRM(CMD_CONFIRM)) u_cmd (
    .clk(clk), .rst_n(rst_core_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .busy_i(stat.busy), .start_o(start)
  );

  ces_ctr #(.AW(AW), .MAX_RETRY(MAX_RETRY), .ERASE_CYC(ERASE_CYC)) u_ctr (
    .clk(clk), .rst_n(rst_core_n), .addr_clr_i(addr_clr), .addr_inc_i(addr_inc),
    .try_clr_i(try_clr), .try_inc_i(try_inc), .tmr_run_i(tmr_run),
    .addr_o(mem_addr), .addr_last_o(addr_last), .try_max_o(try_max), .tmr_done_o(tmr_done)
  );

  ces_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .start_i(start), .mem_rdata_i(mem_rdata),
    .addr_i(mem_addr), .addr_last_i(addr_last), .try_max_i(try_max), .tmr_done_i(tmr_done),
    .mem_we_o(mem_we), .mem_erase_o(mem_erase), .addr_clr_o(addr_clr), .addr_inc_o(addr_inc),
    .try_clr_o(try_clr), .try_inc_o(try_inc), .tmr_run_o(tmr_run), .stat_o(stat)
  );

  assign mem_wdata = '0;
  assign status    = stat;
endmodule

// File: tb/chip_erase_seq_bench.sv
module chip_erase_seq_bench;
  localparam int N  = 16;
  localparam int MR = 3;
  localparam int EC = 5;
  localparam logic [7:0] SETUP = 8'h20;
  localparam logic [7:0] CONF  = 8'hD0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic [3:0] mem_addr;
  logic       mem_we, mem_erase;
  logic [7:0] mem_wdata, mem_rdata;
  logic [3:0] status;
  logic [7:0] arr [N];

  int checks = 0, errors = 0;
  bit finished = 0;
  int wp_addr, wp_need, wp_cnt, we_addr, we_need, pulses, writes, quiet_viol;
  logic s_we, s_er, prev_er;
  logic [3:0] s_addr;
  int ph, ma, mt, mtm;
  bit armed, m_dn, m_pf, m_ef;
  logic [7:0] m_rd;

  always #2 clk = ~clk;

  assign mem_rdata = arr[mem_addr];

  chip_erase_seq u_chip_erase_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_erase(mem_erase),
    .mem_rdata(mem_rdata), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: phases 0 idle, 1 write zero, 2 zero check, 3 erase, 4 ones check
  always @(posedge clk) begin
    if (rst_n) begin
      m_rd = arr[ma];
      case (ph)
        0: begin
          if (cmd_valid && armed && cmd_code == CONF) begin
            ph = 1; ma = 0; mt = 0; m_dn = 0; m_pf = 0; m_ef = 0;
          end
          if (cmd_valid) armed = (cmd_code == SETUP);
        end
        1: begin ph = 2; armed = 0; end
        2: begin
          armed = 0;
          if (m_rd == 8'h00) begin
            mt = 0;
            if (ma == N - 1) begin ph = 3; ma = 0; mtm = 0; end
            else begin ma++; ph = 1; end
          end else if (mt == MR) begin ph = 0; m_pf = 1; end
          else begin mt++; ph = 1; end
        end
        3: begin
          armed = 0;
          if (mtm == EC - 1) begin ph = 4; mtm = 0; end
          else mtm++;
        end
        default: begin
          armed = 0;
          if (m_rd == 8'hFF) begin
            if (ma == N - 1) begin ph = 0; m_dn = 1; end
            else begin ma++; mt = 0; end
          end else if (mt == MR) begin ph = 0; m_ef = 1; end
          else begin mt++; ph = 3; mtm = 0; end
        end
      endcase
      // Behavioural array with weak words
      if (s_we) begin
        writes++;
        if (int'(s_addr) == wp_addr) begin
          wp_cnt++;
          if (wp_cnt >= wp_need) arr[s_addr] = 8'h00;
        end else arr[s_addr] = 8'h00;
      end
      if (s_er && !prev_er) begin
        pulses++;
        for (int i = 0; i < N; i++)
          if (!(i == we_addr && pulses < we_need)) arr[i] = 8'hFF;
      end
      prev_er = s_er;
    end
  end

  always @(negedge clk) begin
    s_we = mem_we; s_er = mem_erase; s_addr = mem_addr;
    if (rst_n === 1'b1) begin
      if (!status[0] && (mem_we || mem_erase)) quiet_viol++;
      chk("R2", int'(status), int'({m_ef, m_pf, m_dn, ph != 0}), "status vs model");
      chk("R3", int'(mem_we), int'(ph == 1), "write strobe vs model");
      chk("R5", int'(mem_erase), int'(ph == 3), "erase strobe vs model");
      if (ph != 0) chk(ph >= 3 ? "R6" : "R3", int'(mem_addr), ma, "address vs model");
    end
  end

  task automatic send(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 8'h00;
  endtask

  task automatic fill(input int wpa, input int wpn, input int wea, input int wen);
    for (int i = 0; i < N; i++) arr[i] = 8'((i * 37 + 11) & 255);
    arr[0] = 8'h00; arr[1] = 8'hFF; arr[wpa] = 8'h5A;
    wp_addr = wpa; wp_need = wpn; wp_cnt = 0;
    we_addr = wea; we_need = wen; pulses = 0; writes = 0;
  endtask

  task automatic start_run();
    send(SETUP);
    send(CONF);
    chk("R2", int'(status[0]), 1, "busy after confirm");
    chk("R2", int'(status[3:1]), 0, "done/fail cleared at start");
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && status[0]; i++) @(negedge clk);
  endtask

  task automatic all_ones(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++) if (arr[i] != 8'hFF) bad++;
    chk(req, bad, 0, "words not all ones");
  endtask

  initial begin
    #600000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 8'h00;
    ph = 0; ma = 0; mt = 0; mtm = 0; armed = 0; m_dn = 0; m_pf = 0; m_ef = 0;
    quiet_viol = 0; prev_er = 0; s_we = 0; s_er = 0; s_addr = '0;
    fill(5, 1, 9, 1);
    repeat (4) @(negedge clk);
    chk("R10", int'(mem_we | mem_erase), 0, "strobes in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", int'(status), 0, "status after reset");

    // R1: confirm alone, and confirm after an intervening command
    send(CONF);
    repeat (2) @(negedge clk);
    chk("R1", int'(status[0]), 0, "confirm without setup");
    send(SETUP); send(8'h55); send(CONF);
    repeat (2) @(negedge clk);
    chk("R1", int'(status[0]), 0, "confirm after other command");

    // Plain run from mixed contents
    start_run();
    wait_idle();
    chk("R8", int'(status), 4'b0010, "status after clean run");
    chk("R3", writes, N, "writes in clean run");
    chk("R5", pulses, 1, "pulses in clean run");
    all_ones("R8");

    // Weak words that recover within the retry limit
    fill(5, 3, 9, 2);
    start_run();
    wait_idle();
    chk("R4", writes, N + 2, "writes with weak program word");
    chk("R7", pulses, 2, "pulses with weak erase word");
    chk("R7", int'(status), 4'b0010, "status after recovered run");
    all_ones("R8");

    // Program failure
    fill(5, 10, 9, 1);
    start_run();
    wait_idle();
    chk("R4", int'(status), 4'b0100, "status after program failure");
    chk("R4", writes, 5 + MR + 1, "writes before program failure");
    chk("R4", pulses, 0, "no erase after program failure");

    // Erase failure, then restart clears fail bits (checked in start_run)
    fill(5, 1, 9, 10);
    start_run();
    wait_idle();
    chk("R7", int'(status), 4'b1000, "status after erase failure");
    chk("R7", pulses, MR + 1, "pulses before erase failure");

    // Commands while busy are ignored
    fill(2, 1, 12, 1);
    start_run();
    repeat (6) @(negedge clk);
    send(SETUP); send(CONF); send(SETUP);
    wait_idle();
    chk("R9", int'(status), 4'b0010, "status after run with busy commands");
    chk("R9", writes, N, "writes unchanged by busy commands");
    chk("R9", pulses, 1, "pulses unchanged by busy commands");
    send(CONF);
    repeat (3) @(negedge clk);
    chk("R9", int'(status[0]), 0, "setup during busy did not arm");

    // Set-up repeated then confirm still starts
    fill(7, 1, 3, 1);
    send(SETUP);
    start_run();
    wait_idle();
    chk("R1", int'(status), 4'b0010, "setup, setup, confirm starts");
    chk("R10", quiet_viol, 0, "strobes while not busy");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule